// File: doc/BRIEF.md
# Line-Scan Exposure and Readout Sequencer

This block times the two phases of every line of a line-scan sensor: the exposure, during which the pixels integrate light, and the readout, during which the pixels of the previous exposure are clocked out. It has two operating modes. In free-run mode one exposure follows another without any outside event. In triggered mode an exposure starts only when an external pulse asks for it. All durations are counted in clock ticks. The exposure length comes from a configuration register that the control path writes. The readout length is fixed by parameters: the pixel count times the number of clock ticks per pixel.

An exposure ends, and its readout begins a fixed number of ticks later. Meanwhile the exposure of the next line may already be running, so the two phases overlap. When a readout is requested while the previous one is still running, it starts at the moment the previous one finishes. The block reports accepted triggers with a one-cycle acknowledge. Triggers that arrive while the sequencer is busy are dropped and latched into a sticky overrun flag.

Top module: `line_seq`

## Requirements
- R1: While reset is held, expo_o, rdout_o, pix_stb_o, trig_ack_o and ovr_o are all 0, and the length register holds INT_MIN.
- R2: With mode_i = 0 (free run), the first exposure is active in the second cycle after reset is released. Each following exposure starts exactly GAP cycles after the previous one ends.
- R3: In free run, an exposure never lasts fewer cycles than the readout, PIX*DIV. A shorter programmed length is raised to that value.
- R4: The programmed length is saturated into the range INT_MIN to INT_MAX cycles, in both modes.
- R5: A value written with cfg_we_i takes effect only at the next exposure start. An exposure in progress keeps the length it started with.
- R6: A readout starts RO_DLY cycles after the exposure ends and stays active for PIX*DIV cycles. If the previous readout is still running at that point, the new readout starts in the cycle after the previous one ends.
- R7: pix_stb_o pulses once every DIV cycles during a readout, first in the readout's first cycle, which gives PIX pulses per line.
- R8: With mode_i = 1, a rising edge of trig_i seen while the sequencer is idle and no readout is waiting raises trig_ack_o for one cycle. The exposure starts TRIG_LAT cycles after the sampling edge.
- R9: In triggered mode, a rising edge that arrives during the trigger latency, during an exposure or while a readout waits is ignored and sets ovr_o. A one-cycle pulse on ovr_clr_i clears ovr_o. A new rejected edge in the same cycle wins over the clear.
- R10: The exposure of the next line runs while the readout of the previous line is active.
- R11: In triggered mode the exposure lasts exactly the saturated programmed length, with no raise to the readout length, and the sequencer returns to idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = free run, 1 = triggered |
| trig_i | input | 1 | External trigger, synchronous level; the rising edge counts |
| cfg_we_i | input | 1 | Write strobe for the exposure-length register |
| cfg_val_i | input | CNT_W | Requested exposure length in clock ticks |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| expo_o | output | 1 | Exposure active |
| rdout_o | output | 1 | Readout active |
| pix_stb_o | output | 1 | One pulse per pixel slot inside a readout |
| trig_ack_o | output | 1 | Trigger accepted, one cycle |
| ovr_o | output | 1 | Sticky flag for rejected triggers |

## Verification
The assertions assume that trig_i is already synchronous to clk_i and that mode_i changes only while reset is held. They also assume the parameters keep INT_MIN at or above RO_DLY and INT_MAX at or above PIX*DIV. Without these, two readout requests could collide, or the free-run floor could exceed the ceiling. The stimulus drives every input on the falling edge and changes mode only inside a reset pulse. Its triggers are single-cycle pulses spaced by at least one low cycle, so each one is a clean rising edge.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_INT  = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  // Effective exposure length: saturate into [lo, hi]; in free run also
  // raise to the readout length so the readout never falls behind.
  function automatic logic [31:0] eff_len(input logic [31:0] req,
                                          input logic        free_run,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi,
                                          input logic [31:0] ro);
    logic [31:0] v;
    v = req;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    if (free_run && (v < ro)) v = ro;
    return v;
  endfunction

endpackage

// File: rtl/line_seq_trig.sv
module line_seq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic trig_i,
  input  logic idle_i,
  input  logic pend_i,
  input  logic clr_i,
  output logic accept_o,
  output logic ack_o,
  output logic ovr_o
);
  logic trig_q;
  logic rise;
  logic reject;

  assign rise     = trig_i & ~trig_q;
  assign accept_o = rise & mode_i & idle_i & ~pend_i;
  assign reject   = rise & mode_i & ~accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      ack_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      ack_o  <= accept_o;
      if (reject)      ovr_o <= 1'b1;
      else if (clr_i)  ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/line_seq_expo.sv
module line_seq_expo
  import line_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int INT_MIN  = 10,
  parameter int INT_MAX  = 600,
  parameter int TRIG_LAT = 11,
  parameter int GAP      = 12,
  parameter int RO_LEN   = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             accept_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  output logic             expo_o,
  output logic             int_end_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] int_len_o
);
  localparam logic [CNT_W-1:0] LenReset = CNT_W'(INT_MIN);
  localparam logic [CNT_W-1:0] LatM1    = CNT_W'(TRIG_LAT - 1);
  localparam logic [CNT_W-1:0] GapM1    = CNT_W'(GAP - 1);
  localparam logic [CNT_W-1:0] One      = CNT_W'(1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cfg_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] start_len;

  assign start_len = CNT_W'(eff_len(32'(cfg_q), ~mode_i, 32'(INT_MIN),
                                    32'(INT_MAX), 32'(RO_LEN)));

  assign expo_o    = (state == ST_INT);
  assign int_end_o = (state == ST_INT) && (cnt == '0);
  assign idle_o    = (state == ST_IDLE);
  assign int_len_o = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= LenReset;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      len_q <= LenReset;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!mode_i) begin
            state <= ST_INT;
            cnt   <= start_len - One;
            len_q <= start_len;
          end else if (accept_i) begin
            state <= ST_DLY;
            cnt   <= LatM1;
          end
        end
        ST_DLY: begin
          if (cnt == '0) begin
            state <= ST_INT;
            cnt   <= start_len - One;
            len_q <= start_len;
          end else begin
            cnt <= cnt - One;
          end
        end
        ST_INT: begin
          if (cnt == '0) begin
            if (!mode_i) begin
              state <= ST_GAP;
              cnt   <= GapM1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - One;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            if (!mode_i) begin
              state <= ST_INT;
              cnt   <= start_len - One;
              len_q <= start_len;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - One;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_seq_rdout.sv
module line_seq_rdout #(
  parameter int PIX    = 16,
  parameter int DIV    = 3,
  parameter int RO_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_end_i,
  output logic req_o,
  output logic pend_o,
  output logic rdout_o,
  output logic pix_stb_o
);
  localparam int RoLen = PIX * DIV;
  localparam int RoW   = $clog2(RoLen + 1);
  localparam int DivW  = $clog2(DIV + 1);
  localparam int DlyW  = $clog2(RO_DLY + 1);
  localparam logic [RoW-1:0]  RoM1  = RoW'(RoLen - 1);
  localparam logic [DivW-1:0] DivM1 = DivW'(DIV - 1);
  localparam logic [DlyW-1:0] DlyM1 = DlyW'(RO_DLY - 1);

  logic            dly_on;
  logic [DlyW-1:0] dly_cnt;
  logic            ro_on;
  logic [RoW-1:0]  ro_cnt;
  logic [DivW-1:0] div_cnt;
  logic            pend;

  assign req_o     = dly_on && (dly_cnt == '0);
  assign pend_o    = pend;
  assign rdout_o   = ro_on;
  assign pix_stb_o = ro_on && (div_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_on  <= 1'b0;
      dly_cnt <= '0;
    end else if (int_end_i) begin
      dly_on  <= 1'b1;
      dly_cnt <= DlyM1;
    end else if (dly_on) begin
      if (dly_cnt == '0) dly_on  <= 1'b0;
      else               dly_cnt <= dly_cnt - DlyW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ro_on   <= 1'b0;
      ro_cnt  <= '0;
      div_cnt <= '0;
      pend    <= 1'b0;
    end else if (!ro_on) begin
      if (req_o) begin
        ro_on   <= 1'b1;
        ro_cnt  <= RoM1;
        div_cnt <= '0;
      end
    end else if (ro_cnt == '0) begin
      if (pend || req_o) begin
        ro_cnt  <= RoM1;
        div_cnt <= '0;
        pend    <= 1'b0;
      end else begin
        ro_on <= 1'b0;
      end
    end else begin
      ro_cnt  <= ro_cnt - RoW'(1);
      div_cnt <= (div_cnt == DivM1) ? '0 : div_cnt + DivW'(1);
      if (req_o) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/line_seq.sv
module line_seq #(
  parameter int CNT_W    = 16,
  parameter int INT_MIN  = 10,
  parameter int INT_MAX  = 600,
  parameter int TRIG_LAT = 11,
  parameter int RO_DLY   = 2,
  parameter int GAP      = 12,
  parameter int PIX      = 16,
  parameter int DIV      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             trig_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic             ovr_clr_i,
  output logic             expo_o,
  output logic             rdout_o,
  output logic             pix_stb_o,
  output logic             trig_ack_o,
  output logic             ovr_o
);
  localparam int RoLen = PIX * DIV;

  logic             accept_w;
  logic             idle_w;
  logic             pend_w;
  logic             int_end_w;
  logic             ro_req_w;
  logic [CNT_W-1:0] int_len_w;

  line_seq_trig u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .trig_i   (trig_i),
    .idle_i   (idle_w),
    .pend_i   (pend_w),
    .clr_i    (ovr_clr_i),
    .accept_o (accept_w),
    .ack_o    (trig_ack_o),
    .ovr_o    (ovr_o)
  );

  line_seq_expo #(
    .CNT_W    (CNT_W),
    .INT_MIN  (INT_MIN),
    .INT_MAX  (INT_MAX),
    .TRIG_LAT (TRIG_LAT),
    .GAP      (GAP),
    .RO_LEN   (RoLen)
  ) u_expo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .accept_i  (accept_w),
    .cfg_we_i  (cfg_we_i),
    .cfg_val_i (cfg_val_i),
    .expo_o    (expo_o),
    .int_end_o (int_end_w),
    .idle_o    (idle_w),
    .int_len_o (int_len_w)
  );

  line_seq_rdout #(
    .PIX    (PIX),
    .DIV    (DIV),
    .RO_DLY (RO_DLY)
  ) u_rdout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_end_i (int_end_w),
    .req_o     (ro_req_w),
    .pend_o    (pend_w),
    .rdout_o   (rdout_o),
    .pix_stb_o (pix_stb_o)
  );
endmodule

// File: rtl/line_seq_chk.sv
module line_seq_chk #(
  parameter int CNT_W   = 16,
  parameter int INT_MIN = 10,
  parameter int INT_MAX = 600,
  parameter int RO_LEN  = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             expo_i,
  input logic             rdout_i,
  input logic             pix_stb_i,
  input logic             ack_i,
  input logic             ovr_i,
  input logic             req_i,
  input logic [CNT_W-1:0] len_i
);
  localparam logic [CNT_W-1:0] Lo = CNT_W'(INT_MIN);
  localparam logic [CNT_W-1:0] Hi = CNT_W'(INT_MAX);
  localparam logic [CNT_W-1:0] Ro = CNT_W'(RO_LEN);

  p_free_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expo_i && !mode_i) |-> (len_i >= Ro));

  p_len_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expo_i |-> ((len_i >= Lo) && (len_i <= Hi)));

  p_len_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expo_i && $past(expo_i)) |-> $stable(len_i));

  p_ro_after_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdout_i) |-> $past(req_i));

  p_stb_in_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_stb_i |-> rdout_i);

  p_ack_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (!expo_i && mode_i));

  p_ovr_trig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> mode_i);
endmodule

bind line_seq line_seq_chk #(
  .CNT_W   (CNT_W),
  .INT_MIN (INT_MIN),
  .INT_MAX (INT_MAX),
  .RO_LEN  (PIX * DIV)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .expo_i    (expo_o),
  .rdout_i   (rdout_o),
  .pix_stb_i (pix_stb_o),
  .ack_i     (trig_ack_o),
  .ovr_i     (ovr_o),
  .req_i     (ro_req_w),
  .len_i     (int_len_w)
);

// File: tb/sim_line_seq.sv
`timescale 1ns/1ps
module sim_line_seq;
  localparam int MIN = 10, MAX = 600, LAT = 11, DLY = 2, GAP = 12;
  localparam int PIX = 16, DIV = 3, RO = PIX * DIV;

  logic clk = 1'b0;
  logic rst_n, mode, trig, cfg_we, ovr_clr;
  logic [15:0] cfg_val;
  logic expo, rdout, pix, ack, ovr;

  always #2.5 clk = ~clk;

  line_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .trig_i(trig),
    .cfg_we_i(cfg_we), .cfg_val_i(cfg_val), .ovr_clr_i(ovr_clr),
    .expo_o(expo), .rdout_o(rdout), .pix_stb_o(pix),
    .trig_ack_o(ack), .ovr_o(ovr)
  );

  int checks = 0, errors = 0;
  int t;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0d got %0d exp %0d", tag, t, got, exp);
    end
  endtask

  function automatic int ref_len(input int c, input bit free_run);
    int v;
    v = (c < MIN) ? MIN : c;
    v = (v > MAX) ? MAX : v;
    if (free_run && v < RO) v = RO;
    return v;
  endfunction

  // Behavioural reference: event times, not states.
  int nxt_s, arm_s, cur_s, cur_e, busy_until, last_ro_end, cfg_m;
  int wreq[$];
  int wst[$];
  bit tq, e_ack, e_ovr, e_expo, e_ro, e_pix;

  task automatic start_line(input int s, input int e);
    int req, st;
    cur_s = s;
    cur_e = s + e;
    req = s + e + DLY;
    st = (req > last_ro_end) ? req : last_ro_end;
    last_ro_end = st + RO;
    wreq.push_back(req);
    wst.push_back(st);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; nxt_s = 1; arm_s = -1; cur_s = 0; cur_e = 0;
      busy_until = 0; last_ro_end = 0; cfg_m = MIN;
      wreq.delete(); wst.delete();
      tq = 0; e_ack = 0; e_ovr = 0; e_expo = 0; e_ro = 0; e_pix = 0;
    end else begin
      bit rise, pend, rej;
      int e;
      t++;
      rise = trig && !tq;
      tq = trig;
      pend = 0;
      foreach (wreq[i]) if (wreq[i] <= t - 1 && wst[i] > t - 1) pend = 1;
      e_ack = 0;
      rej = 0;
      if (mode) begin
        if (rise) begin
          if (t - 1 >= busy_until && !pend) begin
            e_ack = 1; arm_s = t + LAT; busy_until = 1 << 30;
          end else rej = 1;
        end
        if (t == arm_s) begin
          e = ref_len(cfg_m, 0);
          start_line(t, e);
          busy_until = t + e;
          arm_s = -1;
        end
      end else if (t == nxt_s) begin
        e = ref_len(cfg_m, 1);
        start_line(t, e);
        nxt_s = t + e + GAP;
      end
      e_ovr = rej ? 1'b1 : (ovr_clr ? 1'b0 : e_ovr);
      if (cfg_we) cfg_m = int'(cfg_val);
      while (wst.size() > 0 && wst[0] + RO <= t) begin
        void'(wst.pop_front());
        void'(wreq.pop_front());
      end
      e_expo = (t >= cur_s) && (t < cur_e);
      e_ro = (wst.size() > 0) && (wst[0] <= t);
      e_pix = e_ro && (((t - wst[0]) % DIV) == 0);
    end
  end

  bit seen_ovl = 0;
  always @(negedge clk) begin
    if (rst_n && t > 0) begin
      chk(expo == e_expo, "R2/R11 expo", expo, e_expo);
      chk(rdout == e_ro, "R6 rdout", rdout, e_ro);
      chk(pix == e_pix, "R7 pix_stb", pix, e_pix);
      chk(ack == e_ack, "R8 ack", ack, e_ack);
      chk(ovr == e_ovr, "R9 ovr", ovr, e_ovr);
      if (expo && rdout && !mode) seen_ovl = 1;
    end
  end

  task automatic meas(input int wr_at, input int wr_val, output int len);
    while (!expo) @(negedge clk);
    len = 0;
    while (expo) begin
      if (len == wr_at) begin cfg_we = 1; cfg_val = 16'(wr_val); end
      else cfg_we = 0;
      len++;
      @(negedge clk);
    end
    cfg_we = 0;
  endtask

  task automatic pulse_trig();
    trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  initial begin
    int len, g;
    rst_n = 0; mode = 0; trig = 0; cfg_we = 0; cfg_val = '0; ovr_clr = 0;
    repeat (3) @(negedge clk);
    chk({expo, rdout, pix, ack, ovr} == 5'b0, "R1 reset outputs",
        int'({expo, rdout, pix, ack, ovr}), 0);
    rst_n = 1;
    // free run
    meas(-1, 0, len);   chk(len == RO, "R3 clamp to readout", len, RO);
    meas(2, 100, len);  chk(len == RO, "R5 running length kept", len, RO);
    g = 0;
    while (!expo) begin g++; @(negedge clk); end
    chk(g == GAP, "R2 gap", g, GAP);
    meas(-1, 0, len);   chk(len == 100, "R5 new length", len, 100);
    meas(5, 5000, len); chk(len == 100, "R5 length kept", len, 100);
    meas(-1, 0, len);   chk(len == MAX, "R4 saturate high", len, MAX);
    repeat (60) @(negedge clk);
    chk(seen_ovl, "R10 overlap", int'(seen_ovl), 1);
    // triggered
    rst_n = 0; mode = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; cfg_we = 1; cfg_val = 16'd3;
    @(negedge clk); cfg_we = 0;
    repeat (5) @(negedge clk);
    pulse_trig();
    chk(ack == 1, "R8 accept", ack, 1);
    repeat (2) @(negedge clk);
    pulse_trig();
    chk(ovr == 1, "R9 reject in latency", ovr, 1);
    meas(-1, 0, len);   chk(len == MIN, "R11 R4 saturate low", len, MIN);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr == 0, "R9 clear", ovr, 0);
    repeat (2) @(negedge clk);
    pulse_trig();
    chk(ack == 1, "R8 accept during readout", ack, 1);
    meas(-1, 0, len);
    repeat (4) @(negedge clk);
    pulse_trig();
    chk(ovr == 1, "R9 reject while readout waits", ovr, 1);
    chk(ack == 0, "R9 no ack on reject", ack, 0);
    repeat (120) @(negedge clk);
    ovr_clr = 1; cfg_we = 1; cfg_val = 16'd5000;
    @(negedge clk); ovr_clr = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    pulse_trig();
    meas(-1, 0, len);   chk(len == MAX, "R4 R11 saturate high", len, MAX);
    repeat (80) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired t=%0d got 0 exp 1", t);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule